// File: doc/BRIEF.md
# Upstream Request Filter and Router

This block sits behind three ingress ports and decides the fate of each upstream request header: send it to host memory, pass it as a posted write to another port, answer it with an Unsupported Request completion, or drop it without a response. Port 0 is the chipset link and ports 1 and 2 are expansion links. Each header carries a two-bit kind, a 64-bit address, a tag, a requester ID and a virtual channel number.

Each port owns a base/limit address window. The router takes one header at a time from the ingress ports in round-robin order. It holds the header in a single stage and classifies it there, then offers it to exactly one output channel: host, one of three peer egress channels, or the completion channel. All outputs use valid/ready handshakes. The header stays in the stage until that channel accepts it. Three wrapping event counters report drops, Unsupported Request completions and peer forwards.

Top module: `upf_router`

## Requirements
- R1: After reset no output channel is valid, all three counters read zero, and no ingress ready is raised while no ingress valid is high.
- R2: A posted write (kind code 01) whose address has any of bits 63:36 set is accepted and discarded: nothing appears on any output channel and the drop counter rises by one.
- R3: A read (kind 00) or other request (kind 10 or 11) whose address has any of bits 63:36 set yields one completion with status code 3'b001, the original requester ID and tag, and a destination equal to the ingress port index; the Unsupported Request counter rises by one when the completion is accepted.
- R4: An in-range posted write on virtual channel 0 that hits the window of a port other than its source goes only to that port's peer channel, carrying the source index, address, tag and requester ID, and the peer counter rises by one. A hit means base <= address <= limit, a window is live only when base <= limit, and the lowest port index wins on overlap. All six ordered source/target pairs are allowed.
- R5: A read that hits another port's window is answered with an Unsupported Request completion and never appears on a peer channel.
- R6: A posted write that hits another port's window with a nonzero virtual channel is answered with an Unsupported Request completion.
- R7: Every other in-range request goes to the host channel with address bits 63:36 zero. This includes hits on the source's own window and other-kind requests that hit a peer window.
- R8: At most one ingress port is granted per cycle, and only a requesting one. The grant goes to the first requesting port after the last granted port in circular order. A new header is accepted every cycle while the outputs are ready.
- R9: While an output's ready is low, its held header stays valid with stable fields, and no ingress header is accepted until the held one is taken.
- R10: Each counter changes only on its event, by exactly one, wrapping at CNT_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NPORT | Header valid per ingress port |
| in_ready | output | NPORT | Header accepted per ingress port |
| in_kind | input | 2*NPORT | Request kind per port (00 read, 01 posted write, 10/11 other) |
| in_addr | input | 64*NPORT | Request address per port |
| in_tag | input | 8*NPORT | Tag per port |
| in_rid | input | 16*NPORT | Requester ID per port |
| in_vc | input | 3*NPORT | Virtual channel per port |
| win_base | input | 64*NPORT | Window base per port |
| win_limit | input | 64*NPORT | Window limit (inclusive) per port |
| host_valid | output | 1 | Host request valid |
| host_ready | input | 1 | Host request accepted |
| host_kind | output | 2 | Host request kind |
| host_addr | output | 64 | Host request address |
| host_tag | output | 8 | Host request tag |
| host_rid | output | 16 | Host requester ID |
| host_src | output | PW | Host request source port |
| peer_valid | output | NPORT | Peer write valid per egress port |
| peer_ready | input | NPORT | Peer write accepted per egress port |
| peer_addr | output | 64 | Peer write address |
| peer_tag | output | 8 | Peer write tag |
| peer_rid | output | 16 | Peer requester ID |
| peer_src | output | PW | Peer write source port |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion accepted |
| cpl_status | output | 3 | Completion status (3'b001 Unsupported Request) |
| cpl_tag | output | 8 | Returned tag |
| cpl_rid | output | 16 | Returned requester ID |
| cpl_dst | output | PW | Port the completion returns to |
| cnt_drop | output | CNT_W | Dropped-write counter |
| cnt_ur | output | CNT_W | Unsupported Request counter |
| cnt_peer | output | CNT_W | Peer-forward counter |

## Verification
The bench builds the block with its defaults: NPORT=3, HI_BIT=36 and CNT_W=16. With three ports, all six ordered peer pairs and a full three-way round-robin rotation can be driven. A reach limit of bit 36 lets the bench place addresses on both sides of the 64 GB boundary, 0xF_FFFF_FFFF and 0x10_0000_0000. Windows in the 4 GB to 16 GB range let the bench probe the exact base and limit addresses, the address just above a limit, and a port writing into its own window.

// File: rtl/upf_pkg.sv
`timescale 1ns/1ps
package upf_pkg;
  localparam int ADDR_W = 64;
  localparam int TAG_W  = 8;
  localparam int RID_W  = 16;
  localparam int VC_W   = 3;
  localparam int KIND_W = 2;
  localparam int STAT_W = 3;

  localparam logic [KIND_W-1:0] K_RD = 2'b00;
  localparam logic [KIND_W-1:0] K_WR = 2'b01;

  localparam logic [STAT_W-1:0] ST_UNSUP = 3'b001;

  typedef enum logic [1:0] {
    A_HOST = 2'd0,
    A_PEER = 2'd1,
    A_UR   = 2'd2,
    A_DROP = 2'd3
  } route_e;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
    logic [RID_W-1:0]  rid;
    logic [VC_W-1:0]   vc;
  } hdr_t;

  // Address lies beyond the reach bit when any bit from hi upward is set.
  function automatic logic beyond_reach(input logic [ADDR_W-1:0] a, input int hi);
    return (a >> hi) != '0;
  endfunction

  // Inclusive window test; a window with base above limit is disabled.
  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] base,
                                  input logic [ADDR_W-1:0] lim);
    return (base <= lim) && (a >= base) && (a <= lim);
  endfunction
endpackage

// File: rtl/upf_rr_arb.sv
`timescale 1ns/1ps
module upf_rr_arb #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] grant,
  output logic [IW-1:0] gidx
);
  logic [IW-1:0] last;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    gidx  = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = int'(last) + k;
      if (c >= N) c = c - N;
      if (!found && en && req[c]) begin
        grant[c] = 1'b1;
        gidx     = IW'(c);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= IW'(N - 1);
    else if (|grant) last <= gidx;
  end

  // R8: single grant, only to a requester
  assert_grant_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~req) == '0) && $onehot0(grant));
endmodule

// File: rtl/upf_evt_cnt.sv
`timescale 1ns/1ps
module upf_evt_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt == W'($past(cnt) + 1'b1)));
  assert_cnt_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/upf_classify.sv
`timescale 1ns/1ps
module upf_classify import upf_pkg::*; #(
  parameter int NPORT  = 3,
  parameter int HI_BIT = 36,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  hdr_t                    hdr,
  input  logic [PW-1:0]           src,
  input  logic [NPORT*ADDR_W-1:0] win_base,
  input  logic [NPORT*ADDR_W-1:0] win_limit,
  output route_e                  act,
  output logic [PW-1:0]           dst,
  output logic                    oor,
  output logic                    peer_hit
);
  logic [NPORT-1:0] hit;

  for (genvar g = 0; g < NPORT; g++) begin : g_win
    assign hit[g] = (PW'(g) != src) &&
                    in_win(hdr.addr, win_base[g*ADDR_W +: ADDR_W],
                           win_limit[g*ADDR_W +: ADDR_W]);
  end

  // Lowest index wins when windows overlap.
  always_comb begin
    dst      = '0;
    peer_hit = 1'b0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        dst      = PW'(i);
        peer_hit = 1'b1;
      end
    end
  end

  assign oor = beyond_reach(hdr.addr, HI_BIT);

  always_comb begin
    if (oor) begin
      act = (hdr.kind == K_WR) ? A_DROP : A_UR;
    end else if (peer_hit) begin
      if (hdr.kind == K_WR)      act = (hdr.vc == '0) ? A_PEER : A_UR;
      else if (hdr.kind == K_RD) act = A_UR;
      else                       act = A_HOST;
    end else begin
      act = A_HOST;
    end
  end
endmodule

// File: rtl/upf_router.sv
`timescale 1ns/1ps
module upf_router import upf_pkg::*; #(
  parameter int NPORT  = 3,
  parameter int HI_BIT = 36,
  parameter int CNT_W  = 16,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        in_valid,
  output logic [NPORT-1:0]        in_ready,
  input  logic [NPORT*KIND_W-1:0] in_kind,
  input  logic [NPORT*ADDR_W-1:0] in_addr,
  input  logic [NPORT*TAG_W-1:0]  in_tag,
  input  logic [NPORT*RID_W-1:0]  in_rid,
  input  logic [NPORT*VC_W-1:0]   in_vc,
  input  logic [NPORT*ADDR_W-1:0] win_base,
  input  logic [NPORT*ADDR_W-1:0] win_limit,
  output logic                    host_valid,
  input  logic                    host_ready,
  output logic [KIND_W-1:0]       host_kind,
  output logic [ADDR_W-1:0]       host_addr,
  output logic [TAG_W-1:0]        host_tag,
  output logic [RID_W-1:0]        host_rid,
  output logic [PW-1:0]           host_src,
  output logic [NPORT-1:0]        peer_valid,
  input  logic [NPORT-1:0]        peer_ready,
  output logic [ADDR_W-1:0]       peer_addr,
  output logic [TAG_W-1:0]        peer_tag,
  output logic [RID_W-1:0]        peer_rid,
  output logic [PW-1:0]           peer_src,
  output logic                    cpl_valid,
  input  logic                    cpl_ready,
  output logic [STAT_W-1:0]       cpl_status,
  output logic [TAG_W-1:0]        cpl_tag,
  output logic [RID_W-1:0]        cpl_rid,
  output logic [PW-1:0]           cpl_dst,
  output logic [CNT_W-1:0]        cnt_drop,
  output logic [CNT_W-1:0]        cnt_ur,
  output logic [CNT_W-1:0]        cnt_peer
);
  localparam int NEV = 3;

  // Arbitration
  logic [NPORT-1:0] grant;
  logic [PW-1:0]    gidx;
  logic             stage_free;
  logic             take;

  upf_rr_arb #(.N(NPORT)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(in_valid), .en(stage_free),
    .grant(grant), .gidx(gidx)
  );

  assign in_ready = grant;
  assign take     = |grant;

  // Ingress mux
  hdr_t hdr_in;
  always_comb begin
    hdr_in.kind = in_kind[int'(gidx)*KIND_W +: KIND_W];
    hdr_in.addr = in_addr[int'(gidx)*ADDR_W +: ADDR_W];
    hdr_in.tag  = in_tag[int'(gidx)*TAG_W +: TAG_W];
    hdr_in.rid  = in_rid[int'(gidx)*RID_W +: RID_W];
    hdr_in.vc   = in_vc[int'(gidx)*VC_W +: VC_W];
  end

  // Holding stage
  logic          st_valid;
  hdr_t          st_hdr;
  logic [PW-1:0] st_src;
  logic          st_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_hdr   <= '0;
      st_src   <= '0;
    end else if (take) begin
      st_valid <= 1'b1;
      st_hdr   <= hdr_in;
      st_src   <= gidx;
    end else if (st_done) begin
      st_valid <= 1'b0;
    end
  end

  // Classification of the held header
  route_e        act;
  logic [PW-1:0] dst;
  logic          oor;
  logic          peer_hit;

  upf_classify #(.NPORT(NPORT), .HI_BIT(HI_BIT)) u_cls (
    .hdr(st_hdr), .src(st_src), .win_base(win_base), .win_limit(win_limit),
    .act(act), .dst(dst), .oor(oor), .peer_hit(peer_hit)
  );

  // Named internal events
  logic ev_host, ev_peer, ev_ur, ev_drop;
  assign ev_host = host_valid && host_ready;
  assign ev_peer = |(peer_valid & peer_ready);
  assign ev_ur   = cpl_valid && cpl_ready;
  assign ev_drop = st_valid && (act == A_DROP);
  assign st_done    = ev_host || ev_peer || ev_ur || ev_drop;
  assign stage_free = !st_valid || st_done;

  // Output channels
  assign host_valid = st_valid && (act == A_HOST);
  assign host_kind  = st_hdr.kind;
  assign host_addr  = st_hdr.addr;
  assign host_tag   = st_hdr.tag;
  assign host_rid   = st_hdr.rid;
  assign host_src   = st_src;

  always_comb begin
    peer_valid = '0;
    if (st_valid && (act == A_PEER)) peer_valid[int'(dst)] = 1'b1;
  end
  assign peer_addr = st_hdr.addr;
  assign peer_tag  = st_hdr.tag;
  assign peer_rid  = st_hdr.rid;
  assign peer_src  = st_src;

  assign cpl_valid  = st_valid && (act == A_UR);
  assign cpl_status = ST_UNSUP;
  assign cpl_tag    = st_hdr.tag;
  assign cpl_rid    = st_hdr.rid;
  assign cpl_dst    = st_src;

  // Event counters
  logic [NEV-1:0]   ev_vec;
  logic [CNT_W-1:0] cnt_arr [NEV];
  assign ev_vec = {ev_peer, ev_ur, ev_drop};

  for (genvar e = 0; e < NEV; e++) begin : g_cnt
    upf_evt_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(ev_vec[e]), .cnt(cnt_arr[e])
    );
  end

  assign cnt_drop = cnt_arr[0];
  assign cnt_ur   = cnt_arr[1];
  assign cnt_peer = cnt_arr[2];

  // Assertions
  assert_drop_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |-> (st_hdr.kind == K_WR) && ((st_hdr.addr >> HI_BIT) != '0));
  assert_one_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_valid, cpl_valid, peer_valid}));
  assert_peer_not_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|peer_valid) |-> !peer_valid[int'(st_src)]);
  assert_peer_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|peer_valid) |-> (st_hdr.kind == K_WR));
  assert_peer_vc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|peer_valid) |-> (st_hdr.vc == '0));
  assert_host_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |-> ((host_addr >> HI_BIT) == '0));
  assert_host_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_ready) |=> (host_valid && $stable(host_addr) && $stable(host_tag)));
  assert_cpl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_rid) && $stable(cpl_tag)));
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_done) |-> (in_ready == '0));
endmodule

// File: tb/tb_upf_router.sv
`timescale 1ns/1ps
module tb_upf_router;
  localparam int NP = 3;
  localparam int AW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NP-1:0]    in_valid = '0;
  logic [NP-1:0]    in_ready;
  logic [NP*2-1:0]  in_kind = '0;
  logic [NP*AW-1:0] in_addr = '0;
  logic [NP*8-1:0]  in_tag = '0;
  logic [NP*16-1:0] in_rid = '0;
  logic [NP*3-1:0]  in_vc = '0;
  logic [NP*AW-1:0] win_base, win_limit;
  logic host_valid, host_ready;
  logic [1:0] host_kind;
  logic [63:0] host_addr;
  logic [7:0] host_tag;
  logic [15:0] host_rid;
  logic [1:0] host_src;
  logic [NP-1:0] peer_valid, peer_ready;
  logic [63:0] peer_addr;
  logic [7:0] peer_tag;
  logic [15:0] peer_rid;
  logic [1:0] peer_src;
  logic cpl_valid, cpl_ready;
  logic [2:0] cpl_status;
  logic [7:0] cpl_tag;
  logic [15:0] cpl_rid;
  logic [1:0] cpl_dst;
  logic [15:0] cnt_drop, cnt_ur, cnt_peer;

  upf_router dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_addr(in_addr), .in_tag(in_tag), .in_rid(in_rid),
    .in_vc(in_vc), .win_base(win_base), .win_limit(win_limit),
    .host_valid(host_valid), .host_ready(host_ready), .host_kind(host_kind),
    .host_addr(host_addr), .host_tag(host_tag), .host_rid(host_rid),
    .host_src(host_src), .peer_valid(peer_valid), .peer_ready(peer_ready),
    .peer_addr(peer_addr), .peer_tag(peer_tag), .peer_rid(peer_rid),
    .peer_src(peer_src), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_status(cpl_status), .cpl_tag(cpl_tag), .cpl_rid(cpl_rid),
    .cpl_dst(cpl_dst), .cnt_drop(cnt_drop), .cnt_ur(cnt_ur), .cnt_peer(cnt_peer)
  );

  int n_chk = 0, n_fail = 0;
  int exp_drop = 0, exp_ur = 0, exp_peer = 0;
  bit finished = 0;

  // Output handshake monitor
  int host_n = 0, cpl_n = 0;
  int peer_n [NP];
  logic [63:0] h_addr, p_addr;
  logic [7:0]  h_tag, p_tag, c_tag;
  logic [15:0] c_rid, p_rid;
  logic [1:0]  h_src, p_src, c_dst;
  logic [2:0]  c_stat;
  initial for (int k = 0; k < NP; k++) peer_n[k] = 0;

  always @(negedge clk) if (rst_n) begin
    if (host_valid && host_ready) begin
      host_n++; h_addr = host_addr; h_tag = host_tag; h_src = host_src;
    end
    for (int k = 0; k < NP; k++)
      if (peer_valid[k] && peer_ready[k]) begin
        peer_n[k]++; p_addr = peer_addr; p_tag = peer_tag; p_rid = peer_rid; p_src = peer_src;
      end
    if (cpl_valid && cpl_ready) begin
      cpl_n++; c_rid = cpl_rid; c_tag = cpl_tag; c_dst = cpl_dst; c_stat = cpl_status;
    end
  end

  function automatic logic [63:0] wbase(int d);
    return 64'(d + 1) << 32;
  endfunction
  function automatic logic [63:0] wlim(int d);
    return wbase(d) + 64'h0FFF_FFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_port(int p, logic [1:0] ty, logic [63:0] a, logic [7:0] tg,
                          logic [15:0] rid, logic [2:0] vc);
    in_kind[p*2 +: 2]  = ty;
    in_addr[p*AW +: AW] = a;
    in_tag[p*8 +: 8]   = tg;
    in_rid[p*16 +: 16] = rid;
    in_vc[p*3 +: 3]    = vc;
  endtask

  task automatic send(int p, logic [1:0] ty, logic [63:0] a, logic [7:0] tg,
                      logic [15:0] rid, logic [2:0] vc);
    bit got;
    @(posedge clk); #2;
    set_port(p, ty, a, tg, rid, vc);
    in_valid[p] = 1'b1;
    got = 0;
    while (!got) begin
      @(negedge clk);
      got = in_ready[p];
    end
    @(posedge clk); #2;
    in_valid[p] = 1'b0;
  endtask

  function automatic int peer_total();
    int s = 0;
    for (int k = 0; k < NP; k++) s += peer_n[k];
    return s;
  endfunction

  // kind: 0 host, 1 peer, 2 unsupported completion, 3 drop
  task automatic route_case(string req, int p, logic [1:0] ty, logic [63:0] a,
                            logic [7:0] tg, logic [15:0] rid, logic [2:0] vc,
                            int kind, int dst);
    int h0, c0, t0;
    int pk0 [NP];
    h0 = host_n; c0 = cpl_n; t0 = peer_total();
    for (int k = 0; k < NP; k++) pk0[k] = peer_n[k];
    send(p, ty, a, tg, rid, vc);
    repeat (3) @(negedge clk);
    case (kind)
      0: begin
        chk(host_n == h0 + 1, req, "host count", 64'(host_n - h0), 1);
        chk(h_addr == a, req, "host addr", h_addr, a);
        chk(h_src == 2'(p), req, "host src", 64'(h_src), 64'(p));
        chk(h_tag == tg, req, "host tag", 64'(h_tag), 64'(tg));
        chk(cpl_n == c0 && peer_total() == t0, req, "other outputs", 64'(cpl_n - c0 + peer_total() - t0), 0);
      end
      1: begin
        exp_peer++;
        chk(peer_n[dst] == pk0[dst] + 1, req, "peer count", 64'(peer_n[dst] - pk0[dst]), 1);
        chk(peer_total() == t0 + 1, req, "peer total", 64'(peer_total() - t0), 1);
        chk(p_addr == a, req, "peer addr", p_addr, a);
        chk(p_src == 2'(p), req, "peer src", 64'(p_src), 64'(p));
        chk(p_rid == rid, req, "peer rid", 64'(p_rid), 64'(rid));
        chk(host_n == h0 && cpl_n == c0, req, "other outputs", 64'(host_n - h0 + cpl_n - c0), 0);
      end
      2: begin
        exp_ur++;
        chk(cpl_n == c0 + 1, req, "cpl count", 64'(cpl_n - c0), 1);
        chk(c_stat == 3'b001, req, "cpl status", 64'(c_stat), 1);
        chk(c_rid == rid, req, "cpl rid", 64'(c_rid), 64'(rid));
        chk(c_tag == tg, req, "cpl tag", 64'(c_tag), 64'(tg));
        chk(c_dst == 2'(p), req, "cpl dst", 64'(c_dst), 64'(p));
        chk(host_n == h0 && peer_total() == t0, req, "other outputs", 64'(host_n - h0 + peer_total() - t0), 0);
      end
      default: begin
        exp_drop++;
        chk(host_n == h0 && cpl_n == c0 && peer_total() == t0, req, "drop no output",
            64'(host_n - h0 + cpl_n - c0 + peer_total() - t0), 0);
      end
    endcase
    // R10 counters track events exactly
    chk(cnt_drop == 16'(exp_drop), "R10", "drop counter", 64'(cnt_drop), 64'(exp_drop));
    chk(cnt_ur == 16'(exp_ur), "R10", "ur counter", 64'(cnt_ur), 64'(exp_ur));
    chk(cnt_peer == 16'(exp_peer), "R10", "peer counter", 64'(cnt_peer), 64'(exp_peer));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!host_valid && !cpl_valid && peer_valid == '0, "R1", "outputs idle",
        64'({host_valid, cpl_valid, peer_valid}), 0);
    chk(cnt_drop == 0 && cnt_ur == 0 && cnt_peer == 0, "R1", "counters zero",
        64'(cnt_drop + cnt_ur + cnt_peer), 0);
    chk(in_ready == '0, "R1", "ingress ready idle", 64'(in_ready), 0);
  endtask

  task automatic t_reach();
    route_case("R2", 1, 2'b01, 64'h10_0000_0000, 8'h11, 16'h0101, 3'd0, 3, 0);
    route_case("R2", 0, 2'b01, 64'h8000_0000_0000_0000, 8'h12, 16'h0102, 3'd0, 3, 0);
    route_case("R3", 2, 2'b00, 64'h10_0000_0000, 8'h05, 16'h1234, 3'd0, 2, 0);
    route_case("R3", 0, 2'b10, 64'h4000_0000_0000_0000, 8'h06, 16'h0ABC, 3'd0, 2, 0);
    route_case("R7", 1, 2'b00, 64'hF_FFFF_FFFF, 8'h07, 16'h0200, 3'd0, 0, 0);
    route_case("R7", 2, 2'b01, 64'h1000, 8'h08, 16'h0201, 3'd0, 0, 0);
  endtask

  task automatic t_peer_pairs();
    for (int s = 0; s < NP; s++)
      for (int d = 0; d < NP; d++)
        if (s != d)
          route_case("R4", s, 2'b01, wbase(d) + 64'h40 + 64'(s), 8'(s * 4 + d),
                     16'(16'h0300 + s), 3'd0, 1, d);
  endtask

  task automatic t_edges();
    route_case("R4", 0, 2'b01, wlim(1), 8'h21, 16'h0400, 3'd0, 1, 1);
    route_case("R7", 0, 2'b01, wlim(1) + 1, 8'h22, 16'h0401, 3'd0, 0, 0);
    route_case("R4", 2, 2'b01, wbase(0), 8'h23, 16'h0402, 3'd0, 1, 0);
    route_case("R7", 1, 2'b01, wbase(1) + 8, 8'h24, 16'h0403, 3'd0, 0, 0);
  endtask

  task automatic t_filter();
    route_case("R5", 0, 2'b00, wbase(2) + 64'h100, 8'h31, 16'h0500, 3'd0, 2, 0);
    route_case("R5", 1, 2'b00, wbase(0), 8'h32, 16'h0501, 3'd0, 2, 0);
    route_case("R6", 0, 2'b01, wbase(1) + 4, 8'h33, 16'h0502, 3'd1, 2, 0);
    route_case("R6", 2, 2'b01, wbase(0), 8'h34, 16'h0503, 3'd7, 2, 0);
    route_case("R7", 1, 2'b11, wbase(2), 8'h35, 16'h0504, 3'd0, 0, 0);
  endtask

  task automatic t_backpressure();
    int h0;
    h0 = host_n;
    @(posedge clk); #2 host_ready = 1'b0;
    send(0, 2'b00, 64'h5000, 8'h41, 16'h0600, 3'd0);
    @(posedge clk); #2;
    set_port(1, 2'b00, 64'h6000, 8'h42, 16'h0601, 3'd0);
    in_valid[1] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(host_valid && host_addr == 64'h5000, "R9", "held header", host_addr, 64'h5000);
      chk(in_ready == '0, "R9", "ingress blocked", 64'(in_ready), 0);
    end
    @(posedge clk); #2 host_ready = 1'b1;
    @(negedge clk);
    chk(in_ready[1] == 1'b1, "R9", "ingress resumes", 64'(in_ready), 2);
    @(posedge clk); #2 in_valid[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk(host_n == h0 + 2, "R9", "both delivered", 64'(host_n - h0), 2);
    chk(h_addr == 64'h6000, "R9", "second addr", h_addr, 64'h6000);
  endtask

  task automatic t_round_robin();
    int ord [6];
    int h0;
    h0 = host_n;
    @(posedge clk); #2;
    for (int p = 0; p < NP; p++) set_port(p, 2'b00, 64'h100 * 64'(p + 1), 8'(p), 16'(p), 3'd0);
    in_valid = '1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk($countones(in_ready) == 1, "R8", "one grant per cycle", 64'(in_ready), 1);
      ord[i] = 0;
      for (int p = 0; p < NP; p++) if (in_ready[p]) ord[i] = p;
    end
    @(posedge clk); #2 in_valid = '0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++)
      chk(ord[i + 1] == (ord[i] + 1) % NP, "R8", "rotation", 64'(ord[i + 1]), 64'((ord[i] + 1) % NP));
    chk(host_n == h0 + 6, "R8", "all delivered", 64'(host_n - h0), 6);
  endtask

  initial begin
    for (int d = 0; d < NP; d++) begin
      win_base[d*AW +: AW]  = wbase(d);
      win_limit[d*AW +: AW] = wlim(d);
    end
    host_ready = 1'b1;
    peer_ready = '1;
    cpl_ready  = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_reach();
    t_peer_pairs();
    t_edges();
    t_filter();
    t_backpressure();
    t_round_robin();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule